// File: doc/BRIEF.md
# Scalar FP32 Predicate Compare Unit

This block compares the single-precision value held in bits 31:0 of two 128-bit vector operands under one of eight predicates and writes the outcome as a 32-bit mask. The first operand is both a source and the destination. The mask replaces its low lane, and its three upper lanes pass through to the result untouched. The predicate is picked by the three least significant bits of an 8-bit immediate.

An operation starts with a valid strobe. Exactly one clock later the 128-bit result appears with its own valid strobe. Between operations the result register keeps its last value. The predicates include ordered and unordered tests and the negated forms of equal, less-than and less-or-equal. NaN operands make the negated forms true. Signed zeros count as equal. Negative values are ordered by inverted magnitude.

Top module: `fp32_pred_cmp`

## Requirements
- R1: Only bits 31:0 of each operand affect the mask. Changing bits 127:32 of `src_b` never changes the result.
- R2: Only `imm[2:0]` selects the predicate. Bits 7:3 of `imm` have no effect on the result.
- R3: Predicate codes 0, 1, 2 and 3 test, in that order, equal, less-than, less-or-equal and unordered. Each test is of `src_a` against `src_b`.
- R4: Predicate codes 4, 5, 6 and 7 test, in that order, not-equal, not-less-than, not-less-or-equal and ordered.
- R5: Result bits 31:0 are 32'hFFFFFFFF when the predicate holds and 32'h00000000 when it does not.
- R6: An operand is NaN when bits 30:23 are all ones and bits 22:0 are nonzero. When either operand is NaN, codes 0, 1, 2 and 7 give zeros, and codes 3, 4, 5 and 6 give ones.
- R7: +0 and -0 compare equal. Infinities order by sign: -inf is below every finite value and +inf is above every finite value.
- R8: Of two negative values, the one with the larger bits 30:0 is the smaller.
- R9: Result bits 127:32 equal bits 127:32 of `src_a` from the accepted operation.
- R10: `out_valid` rises exactly one cycle after `in_valid`. A synchronous active-high `rst` clears `out_valid`. `result` holds its value in cycles without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 128 | First source and destination vector |
| src_b | input | 128 | Second source vector |
| imm | input | 8 | Immediate; bits 2:0 choose the predicate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Mask in bits 31:0, `src_a` upper lanes above |

## Verification
Two functions of this block meet in a single evaluation. The unordered detection and the negation of a predicate can both apply at once, and the NaN result is correct only if the negated codes invert the ordered relations together with their unordered outcome. The bench provokes this by sending a NaN operand (quiet and signalling patterns, in either position) under all eight codes, back to back. Each mask is judged against a reference built from an integer ordering key that the bench computes. The same back-to-back stream also checks that the upper lanes of each operation's `src_a` arrive with that operation's own mask.

// File: rtl/fp32_pred_cmp.sv
module fp32_pred_cmp #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8,
  parameter int IMM_W  = 8,
  parameter int PRED_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int MAN_W = LANE_W - EXP_W - 1;
  localparam int MAG_W = LANE_W - 1;

  logic [LANE_W-1:0] a, b;
  logic [PRED_W-1:0] code;
  logic nan_a, nan_b, unord, zeros, mag_eq, mag_lt, eq, lt, hit;
  logic unused_bits;

  assign a    = src_a[LANE_W-1:0];
  assign b    = src_b[LANE_W-1:0];
  assign code = imm[PRED_W-1:0];
  assign unused_bits = ^{src_b[VEC_W-1:LANE_W], imm[IMM_W-1:PRED_W]};

  assign nan_a  = (&a[MAG_W-1:MAN_W]) && (|a[MAN_W-1:0]);
  assign nan_b  = (&b[MAG_W-1:MAN_W]) && (|b[MAN_W-1:0]);
  assign unord  = nan_a | nan_b;
  assign zeros  = (a[MAG_W-1:0] == '0) && (b[MAG_W-1:0] == '0);
  assign mag_eq = a[MAG_W-1:0] == b[MAG_W-1:0];
  assign mag_lt = a[MAG_W-1:0] <  b[MAG_W-1:0];

  assign eq = !unord && (zeros || (a == b));

  always_comb begin
    lt = 1'b0;
    if (!unord && !zeros) begin
      unique case ({a[LANE_W-1], b[LANE_W-1]})
        2'b10:   lt = 1'b1;
        2'b01:   lt = 1'b0;
        2'b00:   lt = mag_lt;
        default: lt = !mag_lt && !mag_eq;
      endcase
    end
  end

  always_comb begin
    unique case (code)
      3'd0: hit = eq;
      3'd1: hit = lt;
      3'd2: hit = lt | eq;
      3'd3: hit = unord;
      3'd4: hit = !eq;
      3'd5: hit = !lt;
      3'd6: hit = !(lt | eq);
      default: hit = !unord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
    if (rst)
      result <= '0;
    else if (in_valid)
      result <= {src_a[VEC_W-1:LANE_W], {LANE_W{hit}}};
  end

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result));
  p_upper_pass_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result[VEC_W-1:LANE_W] == $past(src_a[VEC_W-1:LANE_W]));
  p_full_mask_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result[LANE_W-1:0] == '0 || result[LANE_W-1:0] == '1));
  p_nan_eq_false_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && nan_a && code == 3'd0 |=> result[LANE_W-1:0] == '0);
  p_nan_neq_true_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && nan_b && code == 3'd4 |=> result[LANE_W-1:0] == '1);
  p_zero_equal_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && a[MAG_W-1:0] == '0 && b[MAG_W-1:0] == '0 && code == 3'd0
    |=> result[LANE_W-1:0] == '1);
endmodule

// File: tb/fp32_pred_cmp_test.sv
module fp32_pred_cmp_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [7:0] imm = '0;
  logic out_valid;
  logic [127:0] result;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [31:0] P_ONE = 32'h3F800000, P_TWO = 32'h40000000;
  localparam logic [31:0] N_ONE = 32'hBF800000, N_TWO = 32'hC0000000;
  localparam logic [31:0] P_INF = 32'h7F800000, N_INF = 32'hFF800000;
  localparam logic [31:0] P_ZER = 32'h00000000, N_ZER = 32'h80000000;
  localparam logic [31:0] QNAN  = 32'h7FC00000, SNAN  = 32'hFF800001;
  localparam logic [31:0] MAXF  = 32'h7F7FFFFF;

  always #(PERIOD/2) clk = ~clk;

  fp32_pred_cmp uut (.clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a),
                     .src_b(src_b), .imm(imm), .out_valid(out_valid), .result(result));

  function automatic logic [31:0] okey(logic [31:0] v);
    if (v[30:0] == 0) return 32'h80000000;
    return v[31] ? ~v : {1'b1, v[30:0]};
  endfunction

  function automatic logic [31:0] ref_mask(logic [31:0] a, logic [31:0] b, logic [2:0] c);
    bit na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bit nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    bit un = na || nb;
    bit e  = !un && okey(a) == okey(b);
    bit l  = !un && okey(a) <  okey(b);
    bit r;
    case (c)
      3'd0: r = e;       3'd1: r = l;        3'd2: r = l || e;   3'd3: r = un;
      3'd4: r = !e;      3'd5: r = !l;       3'd6: r = !(l || e);
      default: r = !un;
    endcase
    return r ? 32'hFFFFFFFF : 32'h0;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(string req, logic [127:0] a, logic [127:0] b, logic [7:0] i);
    @(negedge clk);
    src_a = a; src_b = b; imm = i; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {127'b0, out_valid}, 128'd1);
    check(req, result, {a[127:32], ref_mask(a[31:0], b[31:0], i[2:0])});
  endtask

  task automatic t_reset();
    check("R10 reset valid", {127'b0, out_valid}, 128'd0);
    check("R10 reset result", result, 128'd0);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 8; c++) begin
      run_one(c < 4 ? "R3 lt pair" : "R4 lt pair", {96'h0, P_ONE}, {96'h0, P_TWO}, 8'(c));
      run_one(c < 4 ? "R3 eq pair" : "R4 eq pair", {96'h0, P_TWO}, {96'h0, P_TWO}, 8'(c));
      run_one(c < 4 ? "R3 gt pair" : "R4 gt pair", {96'h0, P_TWO}, {96'h0, N_ONE}, 8'(c));
    end
    run_one("R5 true mask", {96'h0, P_ONE}, {96'h0, P_ONE}, 8'd0);
    check("R5 ones", {96'h0, result[31:0]}, {96'h0, 32'hFFFFFFFF});
  endtask

  task automatic t_nan_stream();
    logic [31:0] nans[2] = '{QNAN, SNAN};
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      logic [127:0] a = {32'hA5A50000 + 32'(k), 64'h1234_5678_9ABC_DEF0, (k & 8) ? P_ONE : nans[k % 2]};
      logic [127:0] b = {96'h0, (k & 8) ? nans[k % 2] : N_TWO};
      src_a = a; src_b = b; imm = 8'(k % 8); in_valid = 1'b1;
      @(negedge clk);
      check("R6 nan valid", {127'b0, out_valid}, 128'd1);
      check("R6 nan mask R9", result, {a[127:32], ref_mask(a[31:0], b[31:0], 3'(k % 8))});
    end
    in_valid = 1'b0;
  endtask

  task automatic t_special();
    run_one("R7 zeros eq", {96'h0, P_ZER}, {96'h0, N_ZER}, 8'd0);
    run_one("R7 zeros lt", {96'h0, N_ZER}, {96'h0, P_ZER}, 8'd1);
    run_one("R7 ninf lt", {96'h0, N_INF}, {96'h0, N_TWO}, 8'd1);
    run_one("R7 pinf nle", {96'h0, P_INF}, {96'h0, MAXF}, 8'd6);
    run_one("R7 inf eq", {96'h0, P_INF}, {96'h0, P_INF}, 8'd0);
    run_one("R8 neg lt", {96'h0, N_TWO}, {96'h0, N_ONE}, 8'd1);
    run_one("R8 neg nlt", {96'h0, N_ONE}, {96'h0, N_TWO}, 8'd1);
    run_one("R8 neg le", {96'h0, N_ONE}, {96'h0, N_ONE}, 8'd2);
  endtask

  task automatic t_ignored();
    run_one("R2 imm upper", {96'h0, P_ONE}, {96'h0, P_TWO}, 8'hF9);
    check("R2 lt ones", {96'h0, result[31:0]}, {96'h0, 32'hFFFFFFFF});
    run_one("R2 imm upper eq", {96'h0, P_ONE}, {96'h0, P_TWO}, 8'hA8);
    check("R2 eq zeros", {96'h0, result[31:0]}, 128'h0);
    run_one("R1 b upper", {96'h0, P_TWO}, {32'h0, P_INF, N_INF, P_ONE}, 8'd1);
    check("R1 no effect", {96'h0, result[31:0]}, 128'h0);
    run_one("R9 upper lanes", {96'hDEAD_BEEF_CAFE_F00D_0BAD_F00D, P_ONE}, {96'hFFFF, P_ONE}, 8'd0);
    check("R9 upper", {32'h0, result[127:32]}, {32'h0, 96'hDEAD_BEEF_CAFE_F00D_0BAD_F00D});
  endtask

  task automatic t_idle_hold();
    logic [127:0] held;
    run_one("R10 setup", {96'h77, P_ONE}, {96'h0, P_TWO}, 8'd2);
    held = result;
    @(negedge clk);
    src_a = {96'h99, N_ONE}; src_b = {96'h0, P_TWO}; imm = 8'd0;
    @(negedge clk);
    check("R10 idle valid", {127'b0, out_valid}, 128'd0);
    check("R10 idle hold", result, held);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R10 reset clears", {127'b0, out_valid}, 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_codes();
    t_nan_stream();
    t_special();
    t_ignored();
    t_idle_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule